// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block is one downstream port's status and control word in a USB host root hub. Software reads one word that reports the port's live condition. It also writes that same word, but a written 1 acts as a command and does not store a value. A 1 can set power, start a bus reset, suspend the port, enable the port, cut power, or acknowledge a change flag. A written 0 never does anything. Three sticky change flags record connect, enable and suspend events until software clears them by writing 1.

The port side reports device presence, the speed of the attached device and the end of a resume sequence. A configuration input marks the device as fixed in place. The block drives port power, the bus-reset request, the suspend state and the enable state. A parameterised cycle counter sets how long the reset request is held.

Control rests in a four-state machine:
- `ST_DETACHED`: no device is present.
- `ST_IDLE`: connected, and not resetting or suspended.
- `ST_RESET`: the reset request is being driven.
- `ST_SUSPEND`: suspended, or resuming.

The transitions are:
- attach: `ST_DETACHED` to `ST_IDLE`.
- reset command: `ST_IDLE` or `ST_SUSPEND` to `ST_RESET`.
- counter expiry: `ST_RESET` to `ST_IDLE`.
- suspend command: `ST_IDLE` to `ST_SUSPEND`.
- resume completion: `ST_SUSPEND` to `ST_IDLE`.
- detach: any connected state to `ST_DETACHED`.

Top module: `usb_rh_port_reg`

## Requirements
- R1: After reset the read word is all zero and the power, reset, suspend and enable outputs are all low.
- R2: The read word has these fields:
  - bit 0: connect status.
  - bit 1: enable status.
  - bit 2: suspend status.
  - bit 4: reset in progress.
  - bit 8: power on.
  - bit 9: low-speed device. This bit reads 1 only while connected and the low-speed input is high.
  - bit 16: connect change.
  - bit 17: enable change.
  - bit 18: suspend change.
  - Every other bit reads 0.
- R3: Writing 1 to bit 8 turns power on. Writing 1 to bit 9 turns power off. If both are written together, power ends up off. Writing 0 to either bit changes nothing.
- R4: Writing 1 to bit 4 while connected and not already resetting does three things:
  - It drives the reset request for exactly RST_CYCLES cycles.
  - At the end of the request, enable status reads 1.
  - At the end of the request, suspend status reads 0.
- R5: Writing 1 to bit 2 in `ST_IDLE` suspends the port. A resume_done pulse while suspended does three things: it clears suspend status, it sets enable status and it sets the suspend-change flag. A resume_done pulse in any other state does nothing.
- R6: Writing 1 to bit 1 while connected, and not in reset, sets enable status.
- R7: If bit 1, bit 2 or bit 4 is written as 1 while disconnected, the state does not change and the connect-change flag sets.
- R8: Attach and detach each set the connect-change flag. A detach also does the following:
  - It clears enable status.
  - It clears suspend status.
  - It aborts a running reset.
  - If the port was enabled, it sets the enable-change flag.
- R9: While csc_defer is high, an attach does not set the connect-change flag. Instead the flag sets when the next bus reset completes.
- R10: Writing 1 to bit 16, 17 or 18 clears that flag. Writing 0 has no effect. If an event sets a flag in the same cycle as a write that clears it, the flag ends up set.
- R11: While the reset request is driven, writes of 1 to bits 1, 2 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the command word |
| reg_wr_data | input | REG_W | Command word; each 1 bit is a command |
| reg_rd_data | output | REG_W | Status word |
| dev_present | input | 1 | A device is attached (level) |
| dev_low_speed | input | 1 | The attached device is low speed |
| resume_done | input | 1 | One-cycle pulse that ends a resume |
| csc_defer | input | 1 | Device is non-removable; defer the attach notification |
| port_power_o | output | 1 | Port power enable |
| port_reset_o | output | 1 | Bus reset request |
| port_suspend_o | output | 1 | Port is suspended or resuming |
| port_enable_o | output | 1 | Port is enabled |

## Verification
Two pairs of functions can fall in the same cycle:
- A software write that clears a change flag, and a port event that sets the same flag.
- A command write, and a detach or resume completion that changes the state the command depends on.

The directed part of the bench forces both pairs. It writes the connect-change clear in the cycle in which presence drops, and it issues a reset command in the cycle of a resume pulse. The random part then mixes writes, presence toggles and resume pulses freely. After every cycle, a bench model built from the requirements judges the whole read word and all four port pins.

// File: rtl/usb_rh_pkg.sv
package usb_rh_pkg;

    typedef enum logic [1:0] {
        ST_DETACHED = 2'd0,
        ST_IDLE     = 2'd1,
        ST_RESET    = 2'd2,
        ST_SUSPEND  = 2'd3
    } port_st_e;

    // bit positions of the status/command word
    localparam int unsigned POS_CONN    = 0;
    localparam int unsigned POS_EN      = 1;
    localparam int unsigned POS_SUSP    = 2;
    localparam int unsigned POS_RST     = 4;
    localparam int unsigned POS_PWR     = 8;
    localparam int unsigned POS_LS_POFF = 9;
    localparam int unsigned POS_CHG_LO  = 16;
    localparam int unsigned NUM_CHG     = 3;  // connect, enable, suspend
    localparam int unsigned MIN_WIDTH   = POS_CHG_LO + NUM_CHG;

    typedef struct packed {
        logic                  set_en;
        logic                  set_susp;
        logic                  set_rst;
        logic                  set_pwr;
        logic                  clr_pwr;
        logic [NUM_CHG-1:0]    clr_chg;
    } port_cmd_t;

endpackage

// File: rtl/usb_rh_cmd_decode.sv
module usb_rh_cmd_decode
    import usb_rh_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output port_cmd_t        cmd
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_comb begin
        cmd          = '0;
        cmd.set_en   = wr_en & wr_data[POS_EN];
        cmd.set_susp = wr_en & wr_data[POS_SUSP];
        cmd.set_rst  = wr_en & wr_data[POS_RST];
        cmd.set_pwr  = wr_en & wr_data[POS_PWR];
        cmd.clr_pwr  = wr_en & wr_data[POS_LS_POFF];
        for (int i = 0; i < int'(NUM_CHG); i++) begin
            cmd.clr_chg[i] = wr_en & wr_data[POS_CHG_LO + i];
        end
    end

endmodule

// File: rtl/usb_rh_rst_timer.sv
module usb_rh_rst_timer #(
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (start && (cnt_q == '0)) begin
            cnt_q <= CW'(RST_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cnt_q == CW'(RST_CYCLES))); // R4

    AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !abort) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R11

endmodule

// File: rtl/usb_rh_port_fsm.sv
module usb_rh_port_fsm
    import usb_rh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  port_cmd_t cmd,
    input  logic      dev_present,
    input  logic      dev_low_speed,
    input  logic      resume_done,
    input  logic      tmr_done,
    output logic      tmr_start,
    output logic      tmr_abort,
    output logic      conn_o,
    output logic      ls_o,
    output logic      en_o,
    output logic      susp_o,
    output logic      rst_o,
    output logic      pwr_o,
    output logic      ev_attach,
    output logic      ev_detach,
    output logic      ev_nocon,
    output logic      ev_rst_end,
    output logic      ev_rsm_end,
    output logic      ev_en_lost
);

    port_st_e state_q, state_d;
    logic     en_q, en_d;
    logic     susp_q, susp_d;
    logic     pwr_q, pwr_d;
    logic     ls_q;
    logic     conn;
    logic     cmd_ok;

    assign conn   = (state_q != ST_DETACHED);
    assign cmd_ok = (state_q == ST_IDLE) || (state_q == ST_SUSPEND);

    // event and output decode
    always_comb begin
        ev_attach  = dev_present & ~conn;
        ev_detach  = ~dev_present & conn;
        ev_nocon   = ~conn & (cmd.set_en | cmd.set_susp | cmd.set_rst);
        ev_rst_end = (state_q == ST_RESET) & tmr_done & ~ev_detach;
        ev_rsm_end = (state_q == ST_SUSPEND) & resume_done & ~cmd.set_rst & ~ev_detach;
        ev_en_lost = ev_detach & en_q;
        tmr_start  = cmd_ok & cmd.set_rst & ~ev_detach;
        tmr_abort  = ev_detach;
        conn_o     = conn;
        ls_o       = conn & ls_q;
        en_o       = en_q;
        susp_o     = susp_q;
        rst_o      = (state_q == ST_RESET);
        pwr_o      = pwr_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DETACHED: begin
                if (ev_attach) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (ev_detach)         state_d = ST_DETACHED;
                else if (cmd.set_rst)  state_d = ST_RESET;
                else if (cmd.set_susp) state_d = ST_SUSPEND;
            end
            ST_RESET: begin
                if (ev_detach)     state_d = ST_DETACHED;
                else if (tmr_done) state_d = ST_IDLE;
            end
            ST_SUSPEND: begin
                if (ev_detach)        state_d = ST_DETACHED;
                else if (cmd.set_rst) state_d = ST_RESET;
                else if (resume_done) state_d = ST_IDLE;
            end
            default: state_d = ST_DETACHED;
        endcase
    end

    // status bits
    always_comb begin
        en_d   = en_q;
        susp_d = susp_q;
        if (ev_detach) begin
            en_d   = 1'b0;
            susp_d = 1'b0;
        end else if (ev_rst_end || ev_rsm_end) begin
            en_d   = 1'b1;
            susp_d = 1'b0;
        end else begin
            if (cmd_ok && cmd.set_en) en_d = 1'b1;
            if (state_q == ST_IDLE && state_d == ST_SUSPEND) susp_d = 1'b1;
        end
        if (cmd.clr_pwr)      pwr_d = 1'b0;
        else if (cmd.set_pwr) pwr_d = 1'b1;
        else                  pwr_d = pwr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DETACHED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            susp_q <= 1'b0;
            pwr_q  <= 1'b0;
            ls_q   <= 1'b0;
        end else begin
            en_q   <= en_d;
            susp_q <= susp_d;
            pwr_q  <= pwr_d;
            ls_q   <= dev_low_speed;
        end
    end

    AST_DETACH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conn) |-> (!en_q && !susp_q && state_q != ST_RESET)); // R8

    AST_RESET_ENDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RESET && state_q == ST_IDLE) |-> (en_q && !susp_q)); // R4

    AST_SUSP_NEEDS_CONN: assert property (@(posedge clk) disable iff (!rst_n)
        susp_q |-> conn); // R5

    AST_IGNORE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET && !tmr_done && dev_present) |=> (state_q == ST_RESET)); // R11

    AST_NOCON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nocon && !dev_present) |=> (state_q == ST_DETACHED && !en_q)); // R7

endmodule

// File: rtl/usb_rh_chg_flags.sv
module usb_rh_chg_flags
    import usb_rh_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csc_defer,
    input  logic               ev_attach,
    input  logic               ev_detach,
    input  logic               ev_nocon,
    input  logic               ev_rst_end,
    input  logic               ev_rsm_end,
    input  logic               ev_en_lost,
    input  logic [NUM_CHG-1:0] clr_chg,
    output logic [NUM_CHG-1:0] chg_o
);

    logic               pend_q;
    logic [NUM_CHG-1:0] set_v;
    logic [NUM_CHG-1:0] flag_q;

    // deferred attach notification for non-removable devices
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend_q <= 1'b0;
        else if (ev_detach)               pend_q <= 1'b0;
        else if (ev_attach && csc_defer)  pend_q <= 1'b1;
        else if (ev_rst_end)              pend_q <= 1'b0;
    end

    always_comb begin
        set_v    = '0;
        set_v[0] = ev_detach | (ev_attach & ~csc_defer) | ev_nocon | (ev_rst_end & pend_q);
        set_v[1] = ev_en_lost;
        set_v[2] = ev_rsm_end;
    end

    for (genvar g = 0; g < int'(NUM_CHG); g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[g] <= 1'b0;
            else        flag_q[g] <= (flag_q[g] & ~clr_chg[g]) | set_v[g];
        end

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_chg[g] && !set_v[g]) |=> !flag_q[g]); // R10

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[g] |=> flag_q[g]); // R10
    end

    assign chg_o = flag_q;

    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_attach && csc_defer && !flag_q[0] && !clr_chg[0] && !ev_nocon) |=> !flag_q[0]); // R9

endmodule

// File: rtl/usb_rh_port_reg.sv
module usb_rh_port_reg
    import usb_rh_pkg::*;
#(
    parameter int unsigned REG_W      = 32,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             dev_present,
    input  logic             dev_low_speed,
    input  logic             resume_done,
    input  logic             csc_defer,
    output logic             port_power_o,
    output logic             port_reset_o,
    output logic             port_suspend_o,
    output logic             port_enable_o
);

    port_cmd_t          cmd;
    logic               tmr_start, tmr_abort, tmr_busy, tmr_done;
    logic               conn, ls, en, susp, rst, pwr;
    logic               ev_attach, ev_detach, ev_nocon, ev_rst_end, ev_rsm_end, ev_en_lost;
    logic [NUM_CHG-1:0] chg;
    logic               unused_busy;

    assign unused_busy = tmr_busy;

    usb_rh_cmd_decode #(.REG_W(REG_W)) u_dec (
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .cmd     (cmd)
    );

    usb_rh_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .abort (tmr_abort),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    usb_rh_port_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd           (cmd),
        .dev_present   (dev_present),
        .dev_low_speed (dev_low_speed),
        .resume_done   (resume_done),
        .tmr_done      (tmr_done),
        .tmr_start     (tmr_start),
        .tmr_abort     (tmr_abort),
        .conn_o        (conn),
        .ls_o          (ls),
        .en_o          (en),
        .susp_o        (susp),
        .rst_o         (rst),
        .pwr_o         (pwr),
        .ev_attach     (ev_attach),
        .ev_detach     (ev_detach),
        .ev_nocon      (ev_nocon),
        .ev_rst_end    (ev_rst_end),
        .ev_rsm_end    (ev_rsm_end),
        .ev_en_lost    (ev_en_lost)
    );

    usb_rh_chg_flags u_chg (
        .clk        (clk),
        .rst_n      (rst_n),
        .csc_defer  (csc_defer),
        .ev_attach  (ev_attach),
        .ev_detach  (ev_detach),
        .ev_nocon   (ev_nocon),
        .ev_rst_end (ev_rst_end),
        .ev_rsm_end (ev_rsm_end),
        .ev_en_lost (ev_en_lost),
        .clr_chg    (cmd.clr_chg),
        .chg_o      (chg)
    );

    always_comb begin
        reg_rd_data                                = '0;
        reg_rd_data[POS_CONN]                      = conn;
        reg_rd_data[POS_EN]                        = en;
        reg_rd_data[POS_SUSP]                      = susp;
        reg_rd_data[POS_RST]                       = rst;
        reg_rd_data[POS_PWR]                       = pwr;
        reg_rd_data[POS_LS_POFF]                   = ls;
        reg_rd_data[POS_CHG_LO +: NUM_CHG]         = chg;
    end

    assign port_power_o   = pwr;
    assign port_reset_o   = rst;
    assign port_suspend_o = susp;
    assign port_enable_o  = en;

    initial begin
        assert (REG_W >= MIN_WIDTH) else $error("REG_W too narrow");
    end

    AST_PWR_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_data[POS_LS_POFF]) |=> !port_power_o); // R3

    AST_PWR_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_data[POS_PWR] && !reg_wr_data[POS_LS_POFF]) |=> port_power_o); // R3

    AST_LS_ONLY_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_present |=> !reg_rd_data[POS_LS_POFF]); // R2

endmodule

// File: tb/usb_rh_port_reg_bench.sv
`timescale 1ns/1ps
module usb_rh_port_reg_bench;

    localparam int RSTC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pres = 1'b0, lsp = 1'b0, rsm = 1'b0, dfr = 1'b0;
    logic        p_pwr, p_rst, p_susp, p_en;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    logic m_ccs, m_ls, m_en, m_susp, m_rst, m_pwr, m_csc, m_pesc, m_pssc, m_pend;
    int   m_cnt;

    always #2.5 clk = ~clk;

    usb_rh_port_reg #(.REG_W(32), .RST_CYCLES(RSTC)) u_usb_rh_port_reg (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_en      (wr_en),
        .reg_wr_data    (wr_data),
        .reg_rd_data    (rd_data),
        .dev_present    (pres),
        .dev_low_speed  (lsp),
        .resume_done    (rsm),
        .csc_defer      (dfr),
        .port_power_o   (p_pwr),
        .port_reset_o   (p_rst),
        .port_suspend_o (p_susp),
        .port_enable_o  (p_en)
    );

    function automatic logic [31:0] exp_rd();
        logic [31:0] v = '0;
        v[0] = m_ccs; v[1] = m_en; v[2] = m_susp; v[4] = m_rst;
        v[8] = m_pwr; v[9] = m_ccs & m_ls;
        v[16] = m_csc; v[17] = m_pesc; v[18] = m_pssc;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ccs = 0; m_ls = 0; m_en = 0; m_susp = 0; m_rst = 0; m_pwr = 0;
        m_csc = 0; m_pesc = 0; m_pssc = 0; m_pend = 0; m_cnt = 0;
    endtask

    task automatic model_step(input logic w, input logic [31:0] d);
        logic w_en, w_sp, w_rs, att, det, nocon, rdone, rend, s_csc, s_pesc;
        w_en  = w & d[1]; w_sp = w & d[2]; w_rs = w & d[4];
        att   = pres & ~m_ccs;
        det   = ~pres & m_ccs;
        nocon = ~m_ccs & (w_en | w_sp | w_rs);
        rdone = m_ccs & ~det & m_rst & (m_cnt == 1);
        rend  = m_ccs & ~det & ~m_rst & m_susp & rsm & ~w_rs;
        s_csc  = det | (att & ~dfr) | nocon | (rdone & m_pend);
        s_pesc = det & m_en;
        m_csc  = (m_csc  & ~(w & d[16])) | s_csc;
        m_pesc = (m_pesc & ~(w & d[17])) | s_pesc;
        m_pssc = (m_pssc & ~(w & d[18])) | rend;
        if (det)             m_pend = 0;
        else if (att && dfr) m_pend = 1;
        else if (rdone)      m_pend = 0;
        if (w & d[9])      m_pwr = 0;
        else if (w & d[8]) m_pwr = 1;
        if (det) begin
            m_en = 0; m_susp = 0; m_rst = 0; m_cnt = 0;
        end else if (m_ccs) begin
            if (m_rst) begin
                if (rdone) begin m_rst = 0; m_en = 1; m_susp = 0; m_cnt = 0; end
                else m_cnt--;
            end else begin
                if (w_en) m_en = 1;
                if (w_rs) begin m_rst = 1; m_cnt = RSTC; end
                else if (rend) begin m_susp = 0; m_en = 1; end
                else if (w_sp) m_susp = 1;
            end
        end
        m_ccs = pres;
        m_ls  = lsp;
    endtask

    // one cycle: drive at negedge, update model, sample at next negedge
    task automatic step(input logic w, input logic [31:0] d, input logic r);
        wr_en = w; wr_data = d; rsm = r;
        model_step(w, d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; rsm = 1'b0;
        check("R2 read word vs model", rd_data, exp_rd());
        check("R3 R4 R5 R6 port pins vs model", {28'd0, p_pwr, p_rst, p_susp, p_en},
              {28'd0, m_pwr, m_rst, m_susp, m_en});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 read word after reset", rd_data, 32'd0);
        check("R1 pins after reset", {28'd0, p_pwr, p_rst, p_susp, p_en}, 32'd0);
        rst_n = 1'b1;

        // R3 power
        step(1'b1, 32'h100, 1'b0);
        check("R3 power set", {31'd0, p_pwr}, 32'd1);
        step(1'b1, 32'h0, 1'b0);
        check("R3 zero write keeps power", {31'd0, rd_data[8]}, 32'd1);
        step(1'b1, 32'h300, 1'b0);
        check("R3 clear wins over set", {31'd0, p_pwr}, 32'd0);
        step(1'b1, 32'h100, 1'b0);

        // R7 command while disconnected
        step(1'b1, 32'h10, 1'b0);
        check("R7 reset cmd disconnected", rd_data & 32'h0001_0017, 32'h0001_0000);
        step(1'b1, 32'h1_0000, 1'b0);
        check("R10 connect change cleared", {31'd0, rd_data[16]}, 32'd0);

        // R8 attach, low speed (R2)
        pres = 1'b1; lsp = 1'b1;
        step(1'b0, 32'd0, 1'b0);
        idle(1);
        check("R8 attach sets change", rd_data & 32'h0001_0201, 32'h0001_0201);
        step(1'b1, 32'h0, 1'b0);
        check("R10 zero write keeps flag", {31'd0, rd_data[16]}, 32'd1);
        step(1'b1, 32'h1_0000, 1'b0);

        // R5 resume outside suspend ignored, R6 enable
        step(1'b0, 32'd0, 1'b1);
        check("R5 stray resume ignored", rd_data & 32'h0004_0006, 32'd0);
        step(1'b1, 32'h2, 1'b0);
        check("R6 enable set", {31'd0, p_en}, 32'd1);

        // R4 reset timing with R11 ignored writes
        step(1'b1, 32'h10, 1'b0);
        check("R4 reset started", {31'd0, p_rst}, 32'd1);
        for (int i = 0; i < RSTC - 1; i++) begin
            if (i == 3) step(1'b1, 32'h16, 1'b0);
            else        idle(1);
            check("R4 R11 reset still driven", {30'd0, p_rst, p_susp}, 32'd2);
        end
        idle(1);
        check("R4 reset ended enabled", {29'd0, p_rst, p_susp, p_en}, 32'd1);

        // R5 suspend and resume
        step(1'b1, 32'h4, 1'b0);
        check("R5 suspended", {31'd0, p_susp}, 32'd1);
        step(1'b0, 32'd0, 1'b1);
        check("R5 resume end", rd_data & 32'h0004_0006, 32'h0004_0002);
        step(1'b1, 32'h4_0000, 1'b0);

        // reset command in the resume cycle: reset wins
        step(1'b1, 32'h4, 1'b0);
        step(1'b1, 32'h10, 1'b1);
        check("R4 reset beats resume", {29'd0, p_rst, p_susp, rd_data[18]}, 32'd6);
        idle(RSTC);
        check("R4 suspend cleared by reset", {30'd0, p_susp, p_en}, 32'd1);

        // R8 detach while enabled, R10 clear in same cycle as set
        pres = 1'b0;
        step(1'b1, 32'h3_0000, 1'b0);
        check("R8 R10 detach flags win", rd_data & 32'h0003_0007, 32'h0003_0000);
        step(1'b1, 32'h3_0000, 1'b0);

        // R9 deferred attach notice
        dfr = 1'b1; pres = 1'b1;
        idle(2);
        check("R9 attach notice held", {31'd0, rd_data[16]}, 32'd0);
        step(1'b1, 32'h10, 1'b0);
        idle(RSTC);
        check("R9 notice after reset", {31'd0, rd_data[16]}, 32'd1);
        dfr = 1'b0;

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            logic w;
            w = ($urandom % 3) == 0;
            d = $urandom & 32'h0007_0300;
            if ($urandom % 6 == 0)  d[1] = 1'b1;
            if ($urandom % 7 == 0)  d[2] = 1'b1;
            if ($urandom % 12 == 0) d[4] = 1'b1;
            if ($urandom % 25 == 0) d = $urandom;
            if ($urandom % 40 == 0) pres = ~pres;
            if ($urandom % 30 == 0) lsp = ~lsp;
            if ($urandom % 60 == 0) dfr = ~dfr;
            step(w, d, ($urandom % 8) == 0);
        end

        finish_run();
    end

endmodule